// File: doc/BRIEF.md
# Interrupt Priority Resolver with Elevation

This block chooses which pending interrupt the processor should take next and presents that interrupt's vector address. The inputs are a set of maskable peripheral sources, each with a flag and a local enable. There is also an external maskable request pin whose sensitivity can be set to edge or level, an external non-maskable pin, a software-interrupt strobe and an illegal-opcode trap strobe. The block keeps the two global mask bits itself. I gates every maskable source. X gates only the external non-maskable pin. The block also holds a small save stack, so a return strobe can put both bits back as they were before the matching acknowledge.

Maskable sources have a fixed default order, and the highest vector address wins. Software can promote any one maskable source to the top of that order by writing the low byte of its vector into the elevation register. That register accepts a write only while I is set. The non-maskable sources always come first, and their order cannot be changed. The chosen request appears on registered outputs. The consumer takes it with a one-cycle acknowledge and later ends the service with a return strobe.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, I and X both read 1, no request is presented, and the elevation register reads 0x00.
- R2: Non-maskable requests are ranked trap (vector 0xFFF8) above software interrupt (0xFFF6) above external non-maskable pin (0xFFF4), and every one of them beats every maskable request. `req_nmi` is 1 only for these three.
- R3: X blocks only the external non-maskable pin, which is active while `xirq_n` is low. The trap and the software interrupt are still presented while X is 1.
- R4: When I is 1, no maskable request is presented. Peripheral k requests only while `per_flag[k]` and `per_en[k]` are both 1. Its vector is 0xFFF0 − 2k, and the external maskable pin uses 0xFFF2.
- R5: With no elevation match, the active maskable request with the highest vector address wins.
- R6: When bits [7:1] of the elevation register equal bits [7:1] of an active maskable source's vector low byte, that source wins over all other maskable sources. Bit 0 of the register is ignored and reads as 0.
- R7: A write to the elevation register takes effect only if I is 1 in the cycle of the write, judged before any `sei` or `cli` given in that same cycle. In any other case the register keeps its value.
- R8: With `irq_edge_mode` = 0, the external maskable pin requests while it is low and stops when it goes high. With `irq_edge_mode` = 1, a falling edge sets a latch that stays set until that request is acknowledged. A pin held low after the acknowledge raises nothing further.
- R9: When an acknowledge arrives while a request is presented, the block saves {I,X}, sets I, and also sets X when the entry is non-maskable. `req_valid` reads 0 in the following cycle. Each `ret` strobe restores the most recently saved {I,X}, so nested entries unwind in order.
- R10: A software-interrupt or trap strobe stays pending until the request is acknowledged, even while a higher-ranked request is being presented.
- R11: `sei` sets I, `cli` clears I and `clx` clears X. Software has no way to set X.
- R12: The outputs are registered. A change in requests or masks appears on the outputs one cycle after the state that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| per_flag | input | NUM_SRC | Peripheral event flags |
| per_en | input | NUM_SRC | Peripheral local enables |
| irq_n | input | 1 | External maskable request, active low |
| irq_edge_mode | input | 1 | 1 = falling-edge sensitive, 0 = low-level sensitive |
| xirq_n | input | 1 | External non-maskable request, active low |
| swi_stb | input | 1 | Software interrupt strobe |
| trap_stb | input | 1 | Illegal-opcode trap strobe |
| sei | input | 1 | Set I |
| cli | input | 1 | Clear I |
| clx | input | 1 | Clear X |
| elev_wr | input | 1 | Elevation register write strobe |
| elev_wdata | input | 8 | Elevation write data (vector low byte) |
| ack | input | 1 | Accept the presented request |
| ret | input | 1 | Return from service; restore saved I and X |
| req_valid | output | 1 | A request is presented |
| req_vec | output | 16 | Vector address of the presented request |
| req_nmi | output | 1 | Presented request is non-maskable |
| i_mask | output | 1 | Current I bit |
| x_mask | output | 1 | Current X bit |
| elev_val | output | 8 | Elevation register readback |

## Verification
Two of this block's functions can land in the same cycle: a write to the elevation register and a change to the I bit. The bench gives `elev_wr` together with `cli` while I is set, and expects the write to be kept. It then gives `elev_wr` together with `sei` while I is clear, and expects the write to be dropped. The result is read back on `elev_val`. Randomized rounds then draw elevation values, both exact vector bytes with a random bit 0 and arbitrary bytes, along with random flag and enable patterns. Each winner is compared against an ordering model held in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {K_NONE, K_TRAP, K_SWI, K_XIRQ, K_MASK} kind_e;

  localparam logic [7:0] VEC_HI   = 8'hFF;
  localparam logic [7:0] VEC_TRAP = 8'hF8;
  localparam logic [7:0] VEC_SWI  = 8'hF6;
  localparam logic [7:0] VEC_XIRQ = 8'hF4;
  localparam logic [7:0] VEC_IRQ  = 8'hF2;

  // maskable slot 0 is the external pin, slot k+1 is peripheral k
  function automatic logic [7:0] mask_vec_lo(int slot);
    return 8'(int'(VEC_IRQ) - 2 * slot);
  endfunction
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               irq_n,
  input  logic               irq_edge_mode,
  input  logic               swi_stb,
  input  logic               trap_stb,
  input  logic [NUM_SRC-1:0] per_flag,
  input  logic [NUM_SRC-1:0] per_en,
  input  logic               clr_irq,
  input  logic               clr_swi,
  input  logic               clr_trap,
  output logic               irq_act,
  output logic               swi_pend,
  output logic               trap_pend,
  output logic [NUM_SRC-1:0] per_act
);
  logic irq_prev_q, irq_lat_q, fall_now;

  assign fall_now = irq_prev_q & ~irq_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev_q <= 1'b1;
      irq_lat_q  <= 1'b0;
      swi_pend   <= 1'b0;
      trap_pend  <= 1'b0;
    end else begin
      irq_prev_q <= irq_n;
      if (!irq_edge_mode)   irq_lat_q <= 1'b0;
      else if (fall_now)    irq_lat_q <= 1'b1;
      else if (clr_irq)     irq_lat_q <= 1'b0;
      if (swi_stb)          swi_pend  <= 1'b1;
      else if (clr_swi)     swi_pend  <= 1'b0;
      if (trap_stb)         trap_pend <= 1'b1;
      else if (clr_trap)    trap_pend <= 1'b0;
    end
  end

  assign irq_act = irq_edge_mode ? irq_lat_q : ~irq_n;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_local
    assign per_act[g] = per_flag[g] & per_en[g];
  end

  // R8: an acknowledged edge latch drops unless a fresh edge arrives
  a_r8_edge_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_irq && irq_edge_mode && !fall_now) |=> !irq_lat_q);
  // R10: strobed requests persist until cleared by acknowledge
  a_r10_swi_hold: assert property (@(posedge clk) disable iff (rst)
    (swi_pend && !clr_swi) |=> swi_pend);
  a_r10_trap_hold: assert property (@(posedge clk) disable iff (rst)
    (trap_pend && !clr_trap) |=> trap_pend);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int M  = NUM_SRC + 1,
  localparam int IW = $clog2(M + 1)
) (
  input  logic               trap_pend,
  input  logic               swi_pend,
  input  logic               xirq_act,
  input  logic               x_mask,
  input  logic               i_mask,
  input  logic               irq_act,
  input  logic [NUM_SRC-1:0] per_act,
  input  logic [6:0]         elev_sel,
  output kind_e              win_kind,
  output logic [IW-1:0]      win_idx,
  output logic [7:0]         win_lo
);
  logic [M-1:0] mreq, match;
  logic          def_hit, elev_hit;
  logic [IW-1:0] def_idx, elev_idx, sel_idx;

  assign mreq = {per_act, irq_act};

  for (genvar g = 0; g < M; g++) begin : g_match
    localparam logic [7:0] VLO = mask_vec_lo(g);
    assign match[g] = (VLO[7:1] == elev_sel);
  end

  always_comb begin
    def_hit  = 1'b0;
    def_idx  = '0;
    elev_hit = 1'b0;
    elev_idx = '0;
    for (int k = M - 1; k >= 0; k--) begin
      if (mreq[k]) begin
        def_hit = 1'b1;
        def_idx = IW'(k);
      end
      if (mreq[k] && match[k]) begin
        elev_hit = 1'b1;
        elev_idx = IW'(k);
      end
    end
    sel_idx = elev_hit ? elev_idx : def_idx;
  end

  always_comb begin
    win_kind = K_NONE;
    win_idx  = '0;
    win_lo   = 8'h00;
    if (trap_pend) begin
      win_kind = K_TRAP;
      win_lo   = VEC_TRAP;
    end else if (swi_pend) begin
      win_kind = K_SWI;
      win_lo   = VEC_SWI;
    end else if (xirq_act && !x_mask) begin
      win_kind = K_XIRQ;
      win_lo   = VEC_XIRQ;
    end else if (!i_mask && def_hit) begin
      win_kind = K_MASK;
      win_idx  = sel_idx;
      win_lo   = mask_vec_lo(int'(sel_idx));
    end
  end
endmodule

// File: rtl/irq_ccr_stack.sv
module irq_ccr_stack #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic sei,
  input  logic cli,
  input  logic clx,
  input  logic push,
  input  logic push_nmi,
  input  logic pop,
  output logic i_q,
  output logic x_q
);
  logic [1:0]    stk [DEPTH];
  logic [PW-1:0] sp_q;
  logic          do_wr, do_pop;

  assign do_wr  = push && (sp_q < PW'(DEPTH));
  assign do_pop = !push && pop && (sp_q != '0);

  always_ff @(posedge clk) begin
    if (do_wr) stk[sp_q] <= {i_q, x_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
      i_q  <= 1'b1;
      x_q  <= 1'b1;
    end else if (push) begin
      if (do_wr) sp_q <= sp_q + 1'b1;
      i_q <= 1'b1;
      x_q <= x_q | push_nmi;
    end else if (do_pop) begin
      {i_q, x_q} <= stk[sp_q - 1'b1];
      sp_q <= sp_q - 1'b1;
    end else begin
      if (sei)      i_q <= 1'b1;
      else if (cli) i_q <= 1'b0;
      if (clx)      x_q <= 1'b0;
    end
  end

  // R9: every accepted entry leaves I set, and X set for non-maskable ones
  a_r9_entry_sets_i: assert property (@(posedge clk) disable iff (rst)
    push |=> i_q);
  a_r9_nmi_sets_x: assert property (@(posedge clk) disable iff (rst)
    (push && push_nmi) |=> x_q);
  // R11: X can only come back through an entry or a restore
  a_r11_x_no_sw_set: assert property (@(posedge clk) disable iff (rst)
    $rose(x_q) |-> ($past(push) || $past(pop)));
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int STK_DEPTH = 4,
  localparam int M  = NUM_SRC + 1,
  localparam int IW = $clog2(M + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] per_flag,
  input  logic [NUM_SRC-1:0] per_en,
  input  logic               irq_n,
  input  logic               irq_edge_mode,
  input  logic               xirq_n,
  input  logic               swi_stb,
  input  logic               trap_stb,
  input  logic               sei,
  input  logic               cli,
  input  logic               clx,
  input  logic               elev_wr,
  input  logic [7:0]         elev_wdata,
  input  logic               ack,
  input  logic               ret,
  output logic               req_valid,
  output logic [15:0]        req_vec,
  output logic               req_nmi,
  output logic               i_mask,
  output logic               x_mask,
  output logic [7:0]         elev_val
);
  logic               irq_act, swi_pend, trap_pend;
  logic [NUM_SRC-1:0] per_act;
  logic [6:0]         elev_q;
  kind_e              win_kind, kind_q;
  logic [IW-1:0]      win_idx, idx_q;
  logic [7:0]         win_lo, lo_q;
  logic               vld_q, ack_fire;
  logic               unused_bit0;

  assign unused_bit0 = elev_wdata[0];
  assign ack_fire    = ack & vld_q;

  irq_src_cond #(.NUM_SRC(NUM_SRC)) u_src (
    .clk, .rst, .irq_n, .irq_edge_mode, .swi_stb, .trap_stb, .per_flag, .per_en,
    .clr_irq  (ack_fire && kind_q == K_MASK && idx_q == '0),
    .clr_swi  (ack_fire && kind_q == K_SWI),
    .clr_trap (ack_fire && kind_q == K_TRAP),
    .irq_act, .swi_pend, .trap_pend, .per_act
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .trap_pend, .swi_pend, .xirq_act(~xirq_n), .x_mask, .i_mask,
    .irq_act, .per_act, .elev_sel(elev_q),
    .win_kind, .win_idx, .win_lo
  );

  irq_ccr_stack #(.DEPTH(STK_DEPTH)) u_ccr (
    .clk, .rst, .sei, .cli, .clx,
    .push(ack_fire), .push_nmi(kind_q != K_MASK), .pop(ret),
    .i_q(i_mask), .x_q(x_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) elev_q <= 7'd0;
    else if (elev_wr && i_mask) elev_q <= elev_wdata[7:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      kind_q <= K_NONE;
      idx_q  <= '0;
      lo_q   <= 8'h00;
    end else begin
      vld_q  <= !ack_fire && (win_kind != K_NONE);
      kind_q <= win_kind;
      idx_q  <= win_idx;
      lo_q   <= win_lo;
    end
  end

  assign req_valid = vld_q;
  assign req_vec   = {VEC_HI, lo_q};
  assign req_nmi   = vld_q && (kind_q != K_MASK);
  assign elev_val  = {elev_q, 1'b0};

  // R7: elevation register changes only if I was set at the write
  a_r7_elev_guard: assert property (@(posedge clk) disable iff (rst)
    !(elev_wr && i_mask) |=> $stable(elev_q));
  // R3: external non-maskable entry only when X was clear
  a_r3_xirq_gated: assert property (@(posedge clk) disable iff (rst)
    (vld_q && kind_q == K_XIRQ) |-> $past(!x_mask));
  // R4: maskable entry only when I was clear
  a_r4_mask_gated: assert property (@(posedge clk) disable iff (rst)
    (vld_q && kind_q == K_MASK) |-> $past(!i_mask));
  // R2: a maskable winner never hides a pending strobed non-maskable one
  a_r2_nmi_first: assert property (@(posedge clk) disable iff (rst)
    (vld_q && kind_q == K_MASK) |-> $past(!trap_pend && !swi_pend));
endmodule

// File: tb/tb_irq_prio_resolver.sv
module tb_irq_prio_resolver;
  localparam int N = 8;
  localparam int M = N + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] per_flag = '0, per_en = '0;
  logic irq_n = 1'b1, irq_edge_mode = 1'b0, xirq_n = 1'b1;
  logic swi_stb = 0, trap_stb = 0, sei = 0, cli = 0, clx = 0;
  logic elev_wr = 0, ack = 0, ret = 0;
  logic [7:0] elev_wdata = 8'h00;
  logic req_valid, req_nmi, i_mask, x_mask;
  logic [15:0] req_vec;
  logic [7:0] elev_val;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_resolver #(.NUM_SRC(N)) dut (
    .clk, .rst, .per_flag, .per_en, .irq_n, .irq_edge_mode, .xirq_n,
    .swi_stb, .trap_stb, .sei, .cli, .clx, .elev_wr, .elev_wdata,
    .ack, .ret, .req_valid, .req_vec, .req_nmi, .i_mask, .x_mask, .elev_val
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1; tick(1); ack = 0;
  endtask

  task automatic pulse_ret();
    ret = 1; tick(1); ret = 0;
  endtask

  function automatic logic [7:0] vlo(int slot);
    return 8'(242 - 2 * slot);
  endfunction

  // maskable winner model: returns vector low byte, 0 when none
  function automatic logic [7:0] model(logic [M-1:0] act, logic [7:0] ev);
    for (int k = 0; k < M; k++)
      if (act[k] && vlo(k)[7:1] == ev[7:1]) return vlo(k);
    for (int k = 0; k < M; k++)
      if (act[k]) return vlo(k);
    return 8'h00;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    tick(3); rst = 0; tick(1);
    // R1 reset state
    chk("R1 i", i_mask, 1); chk("R1 x", x_mask, 1);
    chk("R1 valid", req_valid, 0); chk("R1 elev", elev_val, 8'h00);

    // R6 bit0 ignored, R7 write with I set
    elev_wr = 1; elev_wdata = 8'hE7; tick(1); elev_wr = 0;
    chk("R6 bit0 reads 0", elev_val, 8'hE6);
    // R7 same cycle as cli: accepted
    elev_wr = 1; elev_wdata = 8'hF0; cli = 1; tick(1); elev_wr = 0; cli = 0;
    chk("R7 write with cli", elev_val, 8'hF0);
    chk("R11 cli", i_mask, 0);
    elev_wr = 1; elev_wdata = 8'hE2; tick(1); elev_wr = 0;
    chk("R7 ignored I clear", elev_val, 8'hF0);
    elev_wr = 1; elev_wdata = 8'hE4; sei = 1; tick(1); elev_wr = 0; sei = 0;
    chk("R7 ignored with sei", elev_val, 8'hF0);
    chk("R11 sei", i_mask, 1);
    elev_wr = 1; elev_wdata = 8'h00; tick(1); elev_wr = 0;

    // R3 X blocks XIRQ only
    xirq_n = 0; tick(3);
    chk("R3 xirq blocked", req_valid, 0);
    trap_stb = 1; swi_stb = 1; tick(1); trap_stb = 0; swi_stb = 0; tick(2);
    chk("R2 trap first", {req_valid, req_nmi, req_vec}, {2'b11, 16'hFFF8});
    pulse_ack();
    chk("R9 valid drops", req_valid, 0);
    tick(3);
    chk("R10 swi held", {req_valid, req_vec}, {1'b1, 16'hFFF6});
    pulse_ack(); tick(3);
    chk("R3 xirq still blocked", req_valid, 0);
    pulse_ret(); pulse_ret();
    clx = 1; cli = 1; tick(1); clx = 0; cli = 0;
    chk("R11 clx", x_mask, 0);
    per_flag[0] = 1; per_en[0] = 1; tick(3);
    chk("R2 xirq over maskable", {req_valid, req_nmi, req_vec}, {2'b11, 16'hFFF4});
    xirq_n = 1; tick(3);
    chk("R4 peripheral 0", {req_valid, req_nmi, req_vec}, {2'b10, 16'hFFF0});

    // R9 nested save/restore
    pulse_ack();
    chk("R9 mask entry", {i_mask, x_mask}, 2'b10);
    swi_stb = 1; tick(1); swi_stb = 0; tick(2);
    chk("R2 swi over active", req_vec, 16'hFFF6);
    pulse_ack();
    chk("R9 nmi entry", {i_mask, x_mask}, 2'b11);
    pulse_ret();
    chk("R9 restore inner", {i_mask, x_mask}, 2'b10);
    pulse_ret();
    chk("R9 restore outer", {i_mask, x_mask}, 2'b00);
    tick(2);
    chk("R12 re-present", {req_valid, req_vec}, {1'b1, 16'hFFF0});
    per_flag = '0; per_en = '0;

    // R8 level and edge
    irq_edge_mode = 0; irq_n = 0; tick(3);
    chk("R8 level low", {req_valid, req_vec}, {1'b1, 16'hFFF2});
    irq_n = 1; tick(3);
    chk("R8 level high", req_valid, 0);
    irq_edge_mode = 1; tick(1); irq_n = 0; tick(3);
    chk("R8 edge latched", {req_valid, req_vec}, {1'b1, 16'hFFF2});
    pulse_ack(); pulse_ret(); tick(3);
    chk("R8 latch cleared by ack", req_valid, 0);
    irq_n = 1; irq_edge_mode = 0;

    // R4 local enable and global mask
    per_flag = 8'hFF; per_en = 8'h00; tick(3);
    chk("R4 enable off", req_valid, 0);
    per_en = 8'hFF; sei = 1; tick(1); sei = 0; tick(2);
    chk("R4 I blocks", req_valid, 0);
    per_flag = '0; per_en = '0;

    // R5/R6 random
    for (int it = 0; it < 200; it++) begin
      logic [7:0] ev;
      logic [N-1:0] f, e;
      logic [M-1:0] act;
      logic [7:0] exp_lo;
      if ($urandom % 2) ev = vlo($urandom % M) | 8'($urandom % 2);
      else ev = 8'($urandom);
      f = N'($urandom); e = N'($urandom);
      act = {f & e, 1'b0};
      exp_lo = model(act, ev);
      sei = 1; tick(1); sei = 0;
      elev_wr = 1; elev_wdata = ev; tick(1); elev_wr = 0;
      per_flag = f; per_en = e; cli = 1; tick(1); cli = 0;
      tick(3);
      if (exp_lo == 8'h00) chk("R5 none", req_valid, 0);
      else chk("R6/R5 winner", {req_valid, req_vec}, {1'b1, 8'hFF, exp_lo});
      per_flag = '0; per_en = '0; tick(1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule